// File: doc/BRIEF.md
# Oversampling SPI Slave with Word Interface

This block is an SPI slave that lives entirely in its own system clock domain. The serial clock, the data input and the chip select from the master never clock any flop. They pass through a two-flop synchronizer into the system clock domain. A further register stage lets the block find serial clock edges by comparing consecutive synchronized samples. Because of this, the master's clock may be fully asynchronous to the slave. The cost is that every response on the slave's output lags the pin event that caused it by a fixed number of system clocks.

The block supports all four clock polarity and phase combinations and either bit order. Data moves through a parallel word interface. A transmit word is taken from `tx_word` when the select activates and at every word boundary. Each completed receive word appears on `rx_word` together with a single-cycle strobe. The select may be tied active permanently, in which case words are framed only by counting sample edges.

In three-wire operation one shared data line carries both directions. Words alternate, starting with a word received from the master. The slave enables its driver only while it sends its own word.

Top module: `sync_spi_slave`

## Requirements
- R1: While `rst` is high and after it is released, `miso_oe` and `rx_valid` are 0 and `rx_word` is all zeros until a word is received.
- R2: Every input pin change (`sck_in`, `mosi_in`, `ss_n_in`) takes effect on the outputs exactly at the third rising `clk` edge after the change, counting the first edge that can capture it. `miso_out` never changes at any other time. `sck_in` must stay in each level for at least 4 `clk` periods.
- R3: `cpol` gives the idle level of `sck_in`. The leading edge leaves idle and the trailing edge returns to it. With `cpha`=0, data is sampled on leading edges; with `cpha`=1, data is sampled on trailing edges. `rx_word` holds the WORD_W sampled bits.
- R4: With `cpha`=0, the first bit of the transmit word is on `miso_out` as a result of the select activating, before any clock edge. Each following bit appears after a trailing edge.
- R5: With `cpha`=1, `miso_out` advances on leading edges. The first leading edge of a word keeps the bit already shown.
- R6: `lsb_first`=1 sends and receives bit 0 first. `lsb_first`=0 sends and receives bit WORD_W-1 first.
- R7: On the WORD_W-th sample edge, `rx_valid` is high for exactly one cycle and `rx_word` holds the received word.
- R8: `tx_word` is captured when the select activates and at each word boundary. With `cpha`=1, the capture happens on the last sample edge. With `cpha`=0, it happens on the trailing edge that follows the last sample edge.
- R9: Releasing `ss_n_in` (active low) before a word completes discards the partial word without any `rx_valid`, drops `miso_oe`, and the next selection starts at bit 0 of a freshly captured word.
- R10: With `ss_n_in` held low through and after reset, the block starts a frame by itself and transfers consecutive words by edge counting alone.
- R11: With `three_wire`=1, words alternate receive then transmit, starting at selection. `miso_oe` is high only while the transmit word is shifted out (turned on when it is captured, off at its last sample edge). No `rx_valid` is given for transmit words.
- R12: With `three_wire`=0, `miso_oe` follows the synchronized select: it is high while the select is active and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| lsb_first | input | 1 | Bit order select, 1 = least significant bit first |
| three_wire | input | 1 | Shared single data line mode |
| sck_in | input | 1 | Serial clock from master (asynchronous) |
| mosi_in | input | 1 | Data from master, or shared line input in three-wire mode |
| ss_n_in | input | 1 | Active-low slave select (asynchronous) |
| tx_word | input | WORD_W | Next word to transmit |
| miso_out | output | 1 | Serial data to master |
| miso_oe | output | 1 | Output enable for the data driver |
| rx_word | output | WORD_W | Last received word |
| rx_valid | output | 1 | One-cycle strobe for a new received word |

## Verification
Every response of this slave falls on the third rising clock edge after the pin change that causes it. This applies to a bit shifted out, a word captured, the output enable switching, and the receive strobe. The bench therefore stamps every expected change with the cycle count at which it drove the pin, plus three. It compares all outputs at every falling edge: a value that arrives one cycle early or late is as wrong as a wrong bit. The serial clock is held for five system clocks per level, so each expected change settles before the next pin event is driven.

// File: rtl/spis_pkg.sv
package spis_pkg;

    // Pin bundle carried through the synchronizer
    typedef struct packed {
        logic sck;
        logic mosi;
        logic ss_n;
    } spi_pins_t;

    // Reset image: clock low, data idle high, select inactive
    localparam spi_pins_t PINS_RST = '{sck: 1'b0, mosi: 1'b1, ss_n: 1'b1};

    // Events derived from synchronized pins, one system clock wide
    typedef struct packed {
        logic act;    // select active (level)
        logic start;  // select just became active
        logic samp;   // sampling edge of the serial clock
        logic shft;   // shifting edge of the serial clock
    } spi_evt_t;

    // Direction of the current word on a shared data line
    typedef enum logic {
        TURN_RX = 1'b0,
        TURN_TX = 1'b1
    } turn_e;

endpackage

// File: rtl/spis_sync.sv
module spis_sync
    import spis_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  spi_pins_t pins_i,
    output spi_pins_t sync_o,
    output spi_pins_t prev_o
);

    // Stage SYNC_STAGES is the extra edge-detect stage
    for (genvar g = 0; g <= SYNC_STAGES; g++) begin : g_stage
        spi_pins_t q;
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) q <= PINS_RST;
                else     q <= pins_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) q <= PINS_RST;
                else     q <= g_stage[g-1].q;
            end
        end
    end

    assign sync_o = g_stage[SYNC_STAGES-1].q;
    assign prev_o = g_stage[SYNC_STAGES].q;

endmodule

// File: rtl/spis_edge.sv
module spis_edge
    import spis_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cpol,
    input  logic      cpha,
    input  spi_pins_t sync_i,
    input  spi_pins_t prev_i,
    output spi_evt_t  evt_o
);

    logic away_now, away_old, lead, trail;

    // "away" = serial clock outside its idle level
    assign away_now = sync_i.sck ^ cpol;
    assign away_old = prev_i.sck ^ cpol;

    always_comb begin
        evt_o.act   = !sync_i.ss_n;
        evt_o.start = !sync_i.ss_n && prev_i.ss_n;
        lead        = evt_o.act && !evt_o.start && away_now && !away_old;
        trail       = evt_o.act && !evt_o.start && !away_now && away_old;
        evt_o.samp  = cpha ? trail : lead;
        evt_o.shft  = cpha ? lead  : trail;
    end

    assert_events_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({evt_o.start, evt_o.samp, evt_o.shft}));

endmodule

// File: rtl/spis_shift.sv
module spis_shift
    import spis_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  spi_evt_t          evt,
    input  logic              mosi_s,
    input  logic              cpha,
    input  logic              lsb_first,
    input  logic              three_wire,
    input  logic [WORD_W-1:0] tx_word,
    output logic              miso,
    output logic              oe,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid
);

    localparam int CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [WORD_W-1:0] tx_sr, rx_sr, rx_next, tx_shifted;
    logic [CNT_W-1:0]  cnt;
    logic              pend_load;
    turn_e             turn;
    logic              done, shift_ok;

    always_comb begin
        rx_next    = lsb_first ? {mosi_s, rx_sr[WORD_W-1:1]}
                               : {rx_sr[WORD_W-2:0], mosi_s};
        tx_shifted = lsb_first ? (tx_sr >> 1) : (tx_sr << 1);
        done       = evt.samp && (cnt == LAST);
        shift_ok   = !three_wire || (turn == TURN_TX);
    end

    assign miso = lsb_first ? tx_sr[0] : tx_sr[WORD_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sr     <= '0;
            rx_sr     <= '0;
            rx_word   <= '0;
            rx_valid  <= 1'b0;
            cnt       <= '0;
            pend_load <= 1'b0;
            turn      <= TURN_RX;
            oe        <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (!evt.act) begin
                cnt       <= '0;
                pend_load <= 1'b0;
                turn      <= TURN_RX;
                oe        <= 1'b0;
            end else if (evt.start) begin
                tx_sr     <= tx_word;
                cnt       <= '0;
                pend_load <= 1'b0;
                turn      <= TURN_RX;
                oe        <= !three_wire;
            end else begin
                if (evt.samp) begin
                    rx_sr <= rx_next;
                    if (done) begin
                        cnt      <= '0;
                        rx_word  <= rx_next;
                        rx_valid <= !(three_wire && turn == TURN_TX);
                        turn     <= (three_wire && turn == TURN_RX) ? TURN_TX : TURN_RX;
                        oe       <= !three_wire || (cpha && turn == TURN_RX);
                        if (cpha) tx_sr     <= tx_word;
                        else      pend_load <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                if (evt.shft) begin
                    if (pend_load) begin
                        tx_sr     <= tx_word;
                        pend_load <= 1'b0;
                        oe        <= !three_wire || (turn == TURN_TX);
                    end else if (shift_ok && !(cpha && cnt == '0)) begin
                        tx_sr <= tx_shifted;
                    end
                end
            end
        end
    end

    assert_valid_single_R7: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    assert_valid_after_sample_R3: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(evt.samp));

    assert_oe_needs_select_R12: assert property (@(posedge clk) disable iff (rst)
        !evt.act |=> !oe);

    assert_miso_only_on_event_R2: assert property (@(posedge clk) disable iff (rst)
        !(evt.start || evt.samp || evt.shft) |=> $stable(miso));

    assert_no_valid_tx_turn_R11: assert property (@(posedge clk) disable iff (rst)
        (three_wire && turn == TURN_TX && done && evt.act && !evt.start) |=> !rx_valid);

endmodule

// File: rtl/sync_spi_slave.sv
module sync_spi_slave
    import spis_pkg::*;
#(
    parameter int WORD_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              lsb_first,
    input  logic              three_wire,
    input  logic              sck_in,
    input  logic              mosi_in,
    input  logic              ss_n_in,
    input  logic [WORD_W-1:0] tx_word,
    output logic              miso_out,
    output logic              miso_oe,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid
);

    spi_pins_t pins, pins_s, pins_p;
    spi_evt_t  evt;

    assign pins = '{sck: sck_in, mosi: mosi_in, ss_n: ss_n_in};

    spis_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pins_i (pins),
        .sync_o (pins_s),
        .prev_o (pins_p)
    );

    spis_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .cpol   (cpol),
        .cpha   (cpha),
        .sync_i (pins_s),
        .prev_i (pins_p),
        .evt_o  (evt)
    );

    spis_shift #(.WORD_W(WORD_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .mosi_s     (pins_s.mosi),
        .cpha       (cpha),
        .lsb_first  (lsb_first),
        .three_wire (three_wire),
        .tx_word    (tx_word),
        .miso       (miso_out),
        .oe         (miso_oe),
        .rx_word    (rx_word),
        .rx_valid   (rx_valid)
    );

endmodule

// File: tb/sim_sync_spi_slave.sv
module sim_sync_spi_slave;

    localparam int CLK_PERIOD = 10;
    localparam int WORD_W     = 8;
    localparam int HALF       = 5;
    localparam int LAT        = 3;

    localparam int K_MISO  = 0;
    localparam int K_OE    = 1;
    localparam int K_VALID = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cpol_r = 1'b0, cpha_r = 1'b0, lsb_r = 1'b0, tw_r = 1'b0;
    logic sck_r = 1'b0, mosi_r = 1'b1, ssn_r = 1'b1;
    logic [WORD_W-1:0] txd_r = '0;
    logic miso, oe, rxv;
    logic [WORD_W-1:0] rxw;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_spi_slave #(.WORD_W(WORD_W)) u0 (
        .clk(clk), .rst(rst), .cpol(cpol_r), .cpha(cpha_r),
        .lsb_first(lsb_r), .three_wire(tw_r),
        .sck_in(sck_r), .mosi_in(mosi_r), .ss_n_in(ssn_r),
        .tx_word(txd_r), .miso_out(miso), .miso_oe(oe),
        .rx_word(rxw), .rx_valid(rxv)
    );

    typedef struct {
        int                due;
        int                kind;
        logic              v;
        logic [WORD_W-1:0] d;
    } ev_t;

    ev_t  evq[$];
    ev_t  cur;
    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    logic exp_miso = 1'b0, exp_oe = 1'b0, exp_valid = 1'b0;
    logic [WORD_W-1:0] exp_rx = '0;
    string tag = "R1";

    logic [WORD_W-1:0] wq [8];
    logic [WORD_W-1:0] mw [8];
    int mj, mn;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic bitof(logic [WORD_W-1:0] w, int k);
        return lsb_r ? w[k] : w[WORD_W-1-k];
    endfunction

    task automatic push(int kind, logic v, logic [WORD_W-1:0] d);
        ev_t e;
        e.due = cyc + LAT; e.kind = kind; e.v = v; e.d = d;
        evq.push_back(e);
    endtask

    task automatic check(string what, logic [WORD_W-1:0] act, logic [WORD_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s at cycle %0d: got %h expected %h", tag, what, cyc, act, exp);
        end
    endtask

    // Reference comparison on every falling edge
    always @(negedge clk) begin
        if (!rst) begin
            exp_valid = 1'b0;
            while (evq.size() > 0 && evq[0].due <= cyc) begin
                cur = evq.pop_front();
                case (cur.kind)
                    K_MISO:  exp_miso = cur.v;
                    K_OE:    exp_oe   = cur.v;
                    default: begin exp_valid = 1'b1; exp_rx = cur.d; end
                endcase
            end
            check("R12 R11 oe", WORD_W'(oe), WORD_W'(exp_oe));
            check("R7 rx_valid", WORD_W'(rxv), WORD_W'(exp_valid));
            if (exp_oe) check("R2 R4 R5 R6 miso", WORD_W'(miso), WORD_W'(exp_miso));
            if (exp_valid) check("R3 R6 R7 rx_word", rxw, exp_rx);
        end
    end

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    // Model hooks for the two edge kinds
    task automatic m_sample();
        mn++;
        if (mn == WORD_W) begin
            if (!tw_r || (mj % 2 == 0)) push(K_VALID, 1'b1, mw[mj]);
            mj++;
            mn = 0;
            if (cpha_r) push(K_MISO, bitof(wq[mj], 0), '0);
            if (tw_r) push(K_OE, cpha_r && (mj % 2 == 1), '0);
        end
    endtask

    task automatic m_shift();
        if (!cpha_r && mn == 0 && mj > 0) begin
            push(K_MISO, bitof(wq[mj], 0), '0);
            if (tw_r) push(K_OE, (mj % 2 == 1), '0);
        end else if (!tw_r || (mj % 2 == 1)) begin
            push(K_MISO, bitof(wq[mj], mn), '0);
        end
    endtask

    task automatic do_reset(logic ss_level);
        evq.delete();
        exp_oe = 1'b0;
        ssn_r = ss_level;
        sck_r = cpol_r;
        rst = 1'b1;
        wait_n(4);
        txd_r = wq[0];
        rst = 1'b0;
        if (!ss_level) begin
            mj = 0; mn = 0;
            push(K_MISO, bitof(wq[0], 0), '0);
            push(K_OE, !tw_r, '0);
        end
        wait_n(8);
    endtask

    task automatic fill(int seed);
        for (int i = 0; i < 8; i++) begin
            wq[i] = WORD_W'(seed * 37 + i * 91 + 5);
            mw[i] = WORD_W'(seed * 53 + i * 29 + 3);
        end
    endtask

    // Runs nwords words; abort_at >= 0 releases select after that many bits of word 0
    task automatic run_words(int nwords, int abort_at);
        for (int j = 0; j < nwords; j++) begin
            for (int k = 0; k < WORD_W; k++) begin
                if (j == 0 && k == abort_at) return;
                if (!cpha_r) begin
                    mosi_r = bitof(mw[j], k);
                    wait_n(HALF);
                    sck_r = ~cpol_r; m_sample();
                    if (k == 0) txd_r = wq[j+1];
                    wait_n(HALF);
                    sck_r = cpol_r; m_shift();
                end else begin
                    sck_r = ~cpol_r; m_shift();
                    mosi_r = bitof(mw[j], k);
                    wait_n(HALF);
                    sck_r = cpol_r; m_sample();
                    if (k == 0) txd_r = wq[j+1];
                    wait_n(HALF);
                end
            end
        end
        wait_n(HALF);
    endtask

    task automatic frame(string t, logic p, logic h, logic l, logic w, int nwords, int abort_at, int seed);
        tag = t;
        cpol_r = p; cpha_r = h; lsb_r = l; tw_r = w;
        sck_r = p;
        fill(seed);
        txd_r = wq[0];
        wait_n(8);
        ssn_r = 1'b0;
        mj = 0; mn = 0;
        push(K_MISO, bitof(wq[0], 0), '0);
        push(K_OE, !w, '0);
        wait_n(HALF);
        run_words(nwords, abort_at);
        ssn_r = 1'b1;
        push(K_OE, 1'b0, '0);
        wait_n(8);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired at cycle %0d: got running expected done", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        fill(1);
        do_reset(1'b1);
        tag = "R1";
        check("R1 reset oe", WORD_W'(oe), '0);
        check("R1 reset rx_valid", WORD_W'(rxv), '0);
        check("R1 reset rx_word", rxw, '0);

        frame("R3 R4 R6 R8 R12 mode0", 1'b0, 1'b0, 1'b0, 1'b0, 3, -1, 2);
        frame("R3 R5 R8 mode1",        1'b0, 1'b1, 1'b0, 1'b0, 3, -1, 3);
        frame("R3 R4 R6 mode2 lsb",    1'b1, 1'b0, 1'b1, 1'b0, 2, -1, 4);
        frame("R3 R5 R6 mode3 lsb",    1'b1, 1'b1, 1'b1, 1'b0, 2, -1, 5);
        frame("R9 abort mode0",        1'b0, 1'b0, 1'b0, 1'b0, 1, 3, 6);
        frame("R9 after abort",        1'b0, 1'b0, 1'b0, 1'b0, 1, -1, 7);
        frame("R9 abort mode3",        1'b1, 1'b1, 1'b0, 1'b0, 1, 5, 8);
        frame("R9 after abort mode3",  1'b1, 1'b1, 1'b0, 1'b0, 1, -1, 9);
        frame("R11 three-wire cpha0",  1'b0, 1'b0, 1'b0, 1'b1, 4, -1, 10);
        frame("R11 three-wire cpha1",  1'b1, 1'b1, 1'b1, 1'b1, 4, -1, 11);

        tag = "R10 tied select";
        cpol_r = 1'b0; cpha_r = 1'b0; lsb_r = 1'b0; tw_r = 1'b0;
        fill(12);
        do_reset(1'b0);
        run_words(3, -1);
        fill(13);
        do_reset(1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule